// File: doc/BRIEF.md
# Shadow-Buffered Burst Sample Memory

This block collects samples that arrive at a slow conversion rate and holds them in a 1024-entry sample memory. A fast processor reads that memory in bursts, one word per clock. While a burst is running, new samples are not written into the memory being read. They go into an 8-entry shadow store instead. When the burst ends, the shadow contents are moved into the sample memory at the fast clock, one word per cycle. The next burst then starts at the first of those moved words. The processor sees the new samples first, followed by the older ones. Each burst is a full frame with no lost input, and the block needs no second frame-sized buffer.

The sample strobe comes from the slow side. It passes through a two-flop synchroniser and a rising-edge detector, so each strobe stores exactly one sample. Outside a burst, samples are written straight into the sample memory at a circular write pointer.

Top module: `shadow_sample_buf`

## Requirements
- R1: After reset, rd_valid, rd_last, busy and overflow are all low, and the first burst begins at address 0.
- R2: Each rising edge of smp_strobe stores exactly one sample: the value on smp_data three clock edges after the strobe rises.
- R3: While no burst or copy is running, each sample is written to the sample memory at the write pointer. The write pointer then advances by one and wraps from MEM_DEPTH-1 to 0.
- R4: A rd_start pulse while idle starts a burst. From the next cycle, rd_valid is high for exactly MEM_DEPTH consecutive cycles. rd_addr steps by one per cycle and wraps modulo MEM_DEPTH. rd_data is the memory word at rd_addr, and rd_last is high only with the final word.
- R5: Samples that arrive during a burst go to the shadow store and do not change any word returned by that burst.
- R6: When a burst ends, busy rises with rd_last. The stored shadow samples are then written, in arrival order, to consecutive addresses starting at the write pointer, one per cycle.
- R7: The next burst begins at the address the write pointer held when the previous burst ended. It therefore returns the moved shadow samples first and the older words after them. When the frame is aligned so that the pointer is at 1016, the burst starts at 1016.
- R8: A sample that arrives while the shadow store already holds SHD_DEPTH samples is dropped, and the overflow flag is set. The flag stays set until reset.
- R9: A rd_start pulse during a burst or while busy is ignored: no extra burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_strobe | input | 1 | Asynchronous new-sample strobe from the converter |
| smp_data | input | DATA_W | Sample value, held stable while the strobe is high |
| rd_start | input | 1 | Request to start a burst read |
| rd_valid | output | 1 | Burst output word is valid |
| rd_addr | output | log2(MEM_DEPTH) | Memory address of the current burst word |
| rd_data | output | DATA_W | Current burst word |
| rd_last | output | 1 | Final word of the burst |
| busy | output | 1 | Shadow copy-back in progress |
| overflow | output | 1 | Sticky flag: a sample was dropped because the shadow store was full |

## Verification
The bench runs several bursts in a row.

- **Pointer rotation.** The write pointer is driven to 1016 and then wrapped through zero. A design that restarted reads at address 0, or at the new write pointer, would return old words where the new samples should come first.
- **Capture count.** Samples are delivered during bursts, so any sample that leaked into the live memory shows up as a data mismatch in that same frame. A strobe captured twice, or missed, shifts every later word and breaks the next frame check.
- **Overflow.** A ninth shadow sample checks that exactly eight are copied and that the sticky flag is raised.
- **Short copy.** A copy of only three samples checks that only the stored samples are copied.
- **Ignored starts.** Start pulses are sent mid-burst and while busy. A design that honoured them would produce a second burst, visible at rd_valid.

// File: rtl/shadow_sample_buf.sv
module shadow_sample_buf #(
  parameter int DATA_W    = 16,
  parameter int MEM_DEPTH = 1024,
  parameter int SHD_DEPTH = 8,
  localparam int AW = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_strobe,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              rd_start,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_last,
  output logic              busy,
  output logic              overflow
);
  localparam int SW = $clog2(SHD_DEPTH);
  localparam int CW = $clog2(SHD_DEPTH + 1);

  typedef enum logic [1:0] {S_IDLE, S_BURST, S_COPY} state_t;
  state_t st;

  logic [2:0]        sync;
  logic [AW-1:0]     wr_ptr, rd_ptr, rd_base, rd_cnt;
  logic [CW-1:0]     shd_cnt, cp_idx;
  logic [DATA_W-1:0] mem [MEM_DEPTH];
  logic [DATA_W-1:0] shd [SHD_DEPTH];

  wire evt      = sync[1] & ~sync[2];
  wire shd_full = shd_cnt == CW'(SHD_DEPTH);
  wire cp_go    = (st == S_COPY) && (cp_idx < shd_cnt);
  wire cp_done  = (st == S_COPY) && !cp_go && !evt;
  wire shd_we   = (st != S_IDLE) && evt && !shd_full;
  wire shd_drop = (st != S_IDLE) && evt && shd_full;
  wire mem_we   = ((st == S_IDLE) && evt) || cp_go;
  wire rd_end   = (st == S_BURST) && (rd_cnt == AW'(MEM_DEPTH - 1));
  wire [DATA_W-1:0] mem_wd = cp_go ? shd[cp_idx[SW-1:0]] : smp_data;

  assign busy = (st == S_COPY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      sync     <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      rd_base  <= '0;
      rd_cnt   <= '0;
      rd_addr  <= '0;
      shd_cnt  <= '0;
      cp_idx   <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      overflow <= 1'b0;
    end else begin
      sync     <= {sync[1:0], smp_strobe};
      rd_valid <= (st == S_BURST);
      rd_last  <= rd_end;
      if (mem_we) wr_ptr <= wr_ptr + 1'b1;
      if (shd_we) shd_cnt <= shd_cnt + 1'b1;
      else if (cp_done) shd_cnt <= '0;
      if (cp_go) cp_idx <= cp_idx + 1'b1;
      else if (cp_done) cp_idx <= '0;
      if (shd_drop) overflow <= 1'b1;
      case (st)
        S_IDLE: if (rd_start) begin
          st     <= S_BURST;
          rd_ptr <= rd_base;
          rd_cnt <= '0;
        end
        S_BURST: begin
          rd_addr <= rd_ptr;
          rd_ptr  <= rd_ptr + 1'b1;
          rd_cnt  <= rd_cnt + 1'b1;
          if (rd_end) begin
            st      <= S_COPY;
            rd_base <= wr_ptr;
          end
        end
        default: if (cp_done) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[wr_ptr] <= mem_wd;
    if (shd_we) shd[shd_cnt[SW-1:0]] <= smp_data;
    if (st == S_BURST) rd_data <= mem[rd_ptr];
  end
endmodule

// File: rtl/shadow_sample_buf_chk.sv
module shadow_sample_buf_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_last,
  input logic          busy,
  input logic          overflow
);
  AST_LAST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> rd_valid); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> (rd_valid && rd_addr == AW'($past(rd_addr) + 1'b1))); // R4
  AST_COPY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n) rd_last |-> busy); // R6
  AST_NO_READ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !rd_valid); // R9
  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R8
endmodule

bind shadow_sample_buf shadow_sample_buf_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_last(rd_last), .busy(busy), .overflow(overflow)
);

// File: tb/test_shadow_sample_buf.sv
module test_shadow_sample_buf;
  localparam int DW = 16;
  localparam int DEPTH = 1024;
  localparam int SHD = 8;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_strobe = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic rd_start = 1'b0;
  logic rd_valid, rd_last, busy, overflow;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int fails = 0;
  int model_mem [DEPTH];
  int m_wp = 0;
  int m_base = 0;
  bit exp_ovf = 1'b0;

  always #5 clk = ~clk;

  shadow_sample_buf #(.DATA_W(DW), .MEM_DEPTH(DEPTH), .SHD_DEPTH(SHD)) i_shadow_sample_buf (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_data(smp_data),
    .rd_start(rd_start), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_last(rd_last), .busy(busy), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_sample(input int v);
    @(negedge clk);
    smp_data = DW'(v);
    smp_strobe = 1'b1;
    repeat (3) @(negedge clk);
    smp_strobe = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_fill(input int n, input int v0);
    for (int i = 0; i < n; i++) begin
      send_sample(v0 + i);
      model_mem[m_wp] = v0 + i;
      m_wp = (m_wp + 1) % DEPTH;
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 rd_last", int'(rd_last), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 overflow", int'(overflow), 0);
  endtask

  task automatic run_burst(input int nsmp, input int v0, input bit poke, input string tag);
    int base;
    int got;
    int derr;
    int aerr;
    int lerr;
    int waitc;
    int busy_at_end;
    int extra;
    int n;
    base = m_base;
    got = 0; derr = 0; aerr = 0; lerr = 0; waitc = 0; extra = 0; busy_at_end = 0;
    @(negedge clk) rd_start = 1'b1;
    @(negedge clk) rd_start = 1'b0;
    fork
      begin
        while (got < DEPTH && waitc < 3000) begin
          @(negedge clk);
          waitc++;
          if (rd_start) rd_start = 1'b0;
          if (rd_valid) begin
            int a;
            a = (base + got) % DEPTH;
            if (int'(rd_addr) != a) aerr++;
            if (int'(rd_data) != model_mem[a]) begin
              if (derr == 0)
                $display("  %s first mismatch at addr %0d: got %0d exp %0d", tag, a, rd_data, model_mem[a]);
              derr++;
            end
            if (rd_last != (got == DEPTH - 1)) lerr++;
            got++;
            if (poke && got == 500) rd_start = 1'b1;
          end
        end
        busy_at_end = int'(busy);
        rd_start = 1'b1;
        @(negedge clk) rd_start = 1'b0;
        repeat (60) begin
          @(negedge clk);
          if (rd_valid) extra++;
        end
      end
      begin
        repeat (4) @(negedge clk);
        for (int i = 0; i < nsmp; i++) send_sample(v0 + i);
      end
    join
    check({tag, " R4 word count"}, got, DEPTH);
    check({tag, " R4 R7 address sequence errors"}, aerr, 0);
    check({tag, " R2 R3 R5 R7 data errors"}, derr, 0);
    check({tag, " R4 rd_last placement errors"}, lerr, 0);
    check({tag, " R6 busy with last word"}, busy_at_end, 1);
    check({tag, " R9 extra words after ignored starts"}, extra, 0);
    n = (nsmp > SHD) ? SHD : nsmp;
    if (nsmp > SHD) exp_ovf = 1'b1;
    m_base = m_wp;
    for (int i = 0; i < n; i++) begin
      model_mem[m_wp] = v0 + i;
      m_wp = (m_wp + 1) % DEPTH;
    end
    check({tag, " R8 overflow flag"}, int'(overflow), int'(exp_ovf));
  endtask

  initial begin
    fork
      begin
        test_reset();
        idle_fill(DEPTH, 16'h1000);
        run_burst(8, 16'h2000, 1'b1, "burstA R1");
        run_burst(0, 0, 1'b0, "burstB R7");
        idle_fill(1008, 16'h4000);
        run_burst(9, 16'h5000, 1'b1, "burstC R8");
        check("R7 next start at 1016", m_base, 1016);
        run_burst(3, 16'h6000, 1'b0, "burstD R7");
        run_burst(0, 0, 1'b0, "burstE R6");
      end
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule